// File: doc/BRIEF.md
# Scaled Watchdog Timer with Event Reload

This block is a watchdog timer programmed through three byte-wide registers on a plain write port with a combinational read-back. Software loads an 8-bit timeout. The counter then steps down once per time unit. The unit is either one pulse of the one-second `tick_i` enable, or sixty of them, selected by a scale bit. When the count runs out, the block sets a sticky expiry flag and raises a one-cycle interrupt request. If enabled, it also drives a fixed-length keyboard-reset pulse.

Activity on the keyboard or mouse interrupt inputs can re-arm the countdown from the last programmed timeout, and each of these sources has its own enable. Software can force an expiry by writing a self-clearing bit. An external keyboard-controller line can also force an expiry when its enable bit is set. The interrupt line number is held in a 4-bit field and exposed on a port so that routing logic outside the block can act on it. The code 2 is treated as the system-management interrupt.

Top module: `scaled_wdt`

## Requirements
- R1: After reset every register reads 0 (address 0 option, 1 count, 2 control, 3 unused) and `irq_o`, `smi_o` and `kbrst_o` are low.
- R2: Writing a non-zero value to the count register (address 1) arms the counter and records it as the reload value. Writing 0 disarms it, and it then never expires on ticks. Reading address 1 returns the current count.
- R3: With option bit 3 clear, an armed, non-expired counter decrements once per cycle in which `tick_i` is high.
- R4: With option bit 3 set, the counter decrements once per 60 `tick_i` pulses. The 60-pulse prescaler restarts whenever the count register is written or a reload occurs.
- R5: When the counter steps from 1 to 0, control bit 4 (expired) is set, the count reads 0, and `irq_o` is high for exactly the one cycle after the expiring tick.
- R6: Control bit 4 is sticky. Writing 1 to it has no effect, and writing 0 clears it. While it is set, the counter neither decrements, reloads nor expires again.
- R7: Writing 1 to control bit 5 causes an immediate expiry (count forced to 0). The bit always reads 0.
- R8: While the counter is armed and not expired, a high `kbd_irq_i` with control bit 6 set, or a high `mouse_irq_i` with control bit 7 set, reloads the count with the last non-zero timeout written. When its enable bit is clear, or when the counter is disarmed, the input is ignored.
- R9: With option bit 2 set, a high `p20_i` causes an immediate expiry. With option bit 2 clear, `p20_i` is ignored.
- R10: If option bit 1 is set at the moment of expiry, `kbrst_o` is high for RST_LEN (16) cycles, starting in the same cycle as `irq_o`. Otherwise `kbrst_o` stays low.
- R11: `irq_sel_o` equals control bits 3:0, and `smi_o` pulses together with `irq_o` when that field equals 2. Control bits 3:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second time-base enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| kbd_irq_i | input | 1 | Keyboard interrupt activity |
| mouse_irq_i | input | 1 | Mouse interrupt activity |
| p20_i | input | 1 | Keyboard-controller force-expiry line |
| irq_o | output | 1 | One-cycle expiry interrupt request |
| irq_sel_o | output | 4 | Selected interrupt line for the expiry event |
| smi_o | output | 1 | Expiry pulse when the line selection is the management interrupt |
| kbrst_o | output | 1 | Keyboard-reset pulse on expiry |

## Verification
Some properties hold on every cycle, and the assertions cover those. An interrupt pulse comes with the expired flag set and a zero count. The pulse never lasts two cycles. The flag only falls after a control write. The count is frozen while the flag stays set without a write. The reset pulse only starts with a fresh expiry. Other behaviour depends on sequences that only the bench scenarios can drive: the exact tick on which a second or minute countdown ends, the prescaler restart on rewrite, reload from enabled versus disabled activity sources, the force and P20 paths, and the reset pulse length. The bench checks all of these against its cycle model.

// File: rtl/swdt_pkg.sv
package swdt_pkg;
  typedef enum logic [1:0] {
    REG_OPT  = 2'd0,
    REG_CNT  = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned OPT_SCALE = 3;
  localparam int unsigned OPT_P20   = 2;
  localparam int unsigned OPT_RST   = 1;
  localparam int unsigned CTL_MOUSE = 7;
  localparam int unsigned CTL_KBD   = 6;
  localparam int unsigned CTL_FORCE = 5;
  localparam int unsigned CTL_FIRED = 4;
  localparam int unsigned SEL_W     = 4;

  typedef struct packed {
    logic             scale_min;
    logic             p20_en;
    logic             rst_en;
    logic             mouse_en;
    logic             kbd_en;
    logic [SEL_W-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/swdt_cfg_regs.sv
module swdt_cfg_regs
  import swdt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic              force_o,
  output logic              fired_clr_o
);
  cfg_t cfg_q, cfg_n;
  logic opt_wr, ctl_wr;

  assign opt_wr = wr_en_i && (addr_i == REG_OPT);
  assign ctl_wr = wr_en_i && (addr_i == REG_CTL);

  always_comb begin
    cfg_n = cfg_q;
    if (opt_wr) begin
      cfg_n.scale_min = wdata_i[OPT_SCALE];
      cfg_n.p20_en    = wdata_i[OPT_P20];
      cfg_n.rst_en    = wdata_i[OPT_RST];
    end
    if (ctl_wr) begin
      cfg_n.mouse_en = wdata_i[CTL_MOUSE];
      cfg_n.kbd_en   = wdata_i[CTL_KBD];
      cfg_n.sel      = wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  assign cfg_o       = cfg_q;
  assign force_o     = ctl_wr && wdata_i[CTL_FORCE];
  assign fired_clr_o = ctl_wr && !wdata_i[CTL_FIRED];
endmodule

// File: rtl/swdt_prescale.sv
module swdt_prescale #(
  parameter int unsigned TICKS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  input  logic scale_min_i,
  output logic unit_tick_o
);
  localparam int unsigned PW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);

  logic [PW-1:0] pre_q, pre_n;
  logic          wrap;

  assign wrap = (pre_q == LAST);

  always_comb begin
    pre_n = pre_q;
    if (restart_i)   pre_n = '0;
    else if (tick_i) pre_n = wrap ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end

  assign unit_tick_o = tick_i && (!scale_min_i || wrap);
endmodule

// File: rtl/swdt_core.sv
module swdt_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             fired_clr_i,
  input  logic             force_i,
  input  logic             p20_hit_i,
  input  logic             act_hit_i,
  input  logic             unit_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fired_o,
  output logic             fire_now_o,
  output logic             irq_o,
  output logic             restart_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n, rel_q, rel_n;
  logic             fired_q, fired_n, irq_q;
  logic             live, armed, reload_evt, expire, fire_evt;

  assign live       = !fired_q;
  assign armed      = (cnt_q != '0);
  assign reload_evt = live && armed && act_hit_i && !cnt_wr_i;
  assign expire     = live && armed && unit_tick_i && (cnt_q == ONE)
                      && !cnt_wr_i && !reload_evt;
  assign fire_evt   = (live && (force_i || p20_hit_i)) || expire;

  always_comb begin
    cnt_n = cnt_q;
    if (fire_evt)                        cnt_n = '0;
    else if (cnt_wr_i)                   cnt_n = cnt_wdata_i;
    else if (reload_evt)                 cnt_n = rel_q;
    else if (live && armed && unit_tick_i) cnt_n = cnt_q - ONE;
  end

  always_comb begin
    rel_n = rel_q;
    if (cnt_wr_i && (cnt_wdata_i != '0)) rel_n = cnt_wdata_i;
  end

  always_comb begin
    fired_n = fired_q;
    if (fire_evt)         fired_n = 1'b1;
    else if (fired_clr_i) fired_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rel_q   <= '0;
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      rel_q   <= rel_n;
      fired_q <= fired_n;
      irq_q   <= fire_evt;
    end
  end

  assign count_o    = cnt_q;
  assign fired_o    = fired_q;
  assign fire_now_o = fire_evt;
  assign irq_o      = irq_q;
  assign restart_o  = cnt_wr_i || reload_evt;
endmodule

// File: rtl/swdt_stretch.sv
module swdt_stretch #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned RW = $clog2(LEN + 1);
  localparam logic [RW-1:0] FULL = RW'(LEN);

  logic [RW-1:0] rem_q, rem_n;

  always_comb begin
    rem_n = rem_q;
    if (trig_i)            rem_n = FULL;
    else if (rem_q != '0)  rem_n = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_n;
  end

  assign pulse_o = (rem_q != '0);
endmodule

// File: rtl/scaled_wdt.sv
module scaled_wdt
  import swdt_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_MIN = 60,
  parameter int unsigned RST_LEN       = 16,
  parameter int unsigned SMI_CODE      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              kbd_irq_i,
  input  logic              mouse_irq_i,
  input  logic              p20_i,
  output logic              irq_o,
  output logic [SEL_W-1:0]  irq_sel_o,
  output logic              smi_o,
  output logic              kbrst_o
);
  cfg_t              cfg;
  logic              force_req, fired_clr, cnt_wr, unit_tick, restart;
  logic              fire_now, fired_q, p20_hit, act_hit;
  logic [DATA_W-1:0] cnt_q;

  assign cnt_wr  = wr_en_i && (addr_i == REG_CNT);
  assign p20_hit = cfg.p20_en && p20_i;
  assign act_hit = (cfg.kbd_en && kbd_irq_i) || (cfg.mouse_en && mouse_irq_i);

  swdt_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cfg_o(cfg), .force_o(force_req), .fired_clr_o(fired_clr)
  );

  swdt_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .restart_i(restart),
    .scale_min_i(cfg.scale_min), .unit_tick_o(unit_tick)
  );

  swdt_core #(.CNT_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_wr_i(cnt_wr), .cnt_wdata_i(wdata_i),
    .fired_clr_i(fired_clr), .force_i(force_req), .p20_hit_i(p20_hit),
    .act_hit_i(act_hit), .unit_tick_i(unit_tick), .count_o(cnt_q),
    .fired_o(fired_q), .fire_now_o(fire_now), .irq_o(irq_o), .restart_o(restart)
  );

  swdt_stretch #(.LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig_i(fire_now && cfg.rst_en), .pulse_o(kbrst_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_OPT: begin
        rdata_o[OPT_SCALE] = cfg.scale_min;
        rdata_o[OPT_P20]   = cfg.p20_en;
        rdata_o[OPT_RST]   = cfg.rst_en;
      end
      REG_CNT: rdata_o = cnt_q;
      REG_CTL: begin
        rdata_o[CTL_MOUSE]   = cfg.mouse_en;
        rdata_o[CTL_KBD]     = cfg.kbd_en;
        rdata_o[CTL_FIRED]   = fired_q;
        rdata_o[SEL_W-1:0]   = cfg.sel;
      end
      default: rdata_o = '0;
    endcase
  end

  assign irq_sel_o = cfg.sel;
  assign smi_o     = irq_o && (cfg.sel == SEL_W'(SMI_CODE));
endmodule

// File: rtl/swdt_chk.sv
module swdt_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic              irq,
  input logic              kbrst,
  input logic [DATA_W-1:0] count,
  input logic              fired
);
  logic ctl_wr;
  assign ctl_wr = wr_en && (addr == swdt_pkg::REG_CTL);

  a_r5_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fired && count == '0));

  a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fired) |-> $past(ctl_wr));

  a_r6_frozen_while_fired: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && $past(fired) && !$past(wr_en)) |-> $stable(count));

  a_r10_rst_on_fresh_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbrst) |-> $rose(fired));
endmodule

bind scaled_wdt swdt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
  .irq(irq_o), .kbrst(kbrst_o), .count(cnt_q), .fired(fired_q)
);

// File: tb/scaled_wdt_tb.sv
module scaled_wdt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, kbd = 1'b0, mouse = 1'b0, p20 = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata_o;
  logic [3:0] irq_sel_o;
  logic       irq_o, smi_o, kbrst_o;

  int tests = 0, fails = 0, irq_cnt = 0, smi_cnt = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  // behavioural reference state
  bit m_scale, m_p20en, m_rsten, m_men, m_ken, m_fired, m_irq;
  int m_sel, m_cnt, m_rel, m_pre, m_rleft;

  always #4 clk = ~clk;

  scaled_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .kbd_irq_i(kbd), .mouse_irq_i(mouse),
    .p20_i(p20), .irq_o(irq_o), .irq_sel_o(irq_sel_o), .smi_o(smi_o),
    .kbrst_o(kbrst_o)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return (m_scale << 3) | (m_p20en << 2) | (m_rsten << 1);
      1: return m_cnt;
      2: return (m_men << 7) | (m_ken << 6) | (m_fired << 4) | m_sel;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_scale = 0; m_p20en = 0; m_rsten = 0; m_men = 0; m_ken = 0;
      m_fired = 0; m_irq = 0; m_sel = 0; m_cnt = 0; m_rel = 0; m_pre = 0; m_rleft = 0;
    end else begin
      bit w_opt, w_cnt, w_ctl, live, armed, unit, rel, fire;
      w_opt = wr_en && addr == 0;
      w_cnt = wr_en && addr == 1;
      w_ctl = wr_en && addr == 2;
      live  = !m_fired;
      armed = m_cnt != 0;
      unit  = tick && (!m_scale || m_pre == 59);
      rel   = live && armed && ((m_ken && kbd) || (m_men && mouse)) && !w_cnt;
      fire  = live && ((w_ctl && wdata[5]) || (m_p20en && p20) ||
                       (armed && unit && m_cnt == 1 && !w_cnt && !rel));
      if (w_cnt || rel) m_pre = 0;
      else if (tick) m_pre = (m_pre == 59) ? 0 : m_pre + 1;
      if (fire && m_rsten) m_rleft = 16;
      else if (m_rleft > 0) m_rleft--;
      if (fire) m_cnt = 0;
      else if (w_cnt) m_cnt = wdata;
      else if (rel) m_cnt = m_rel;
      else if (live && armed && unit) m_cnt--;
      if (w_cnt && wdata != 0) m_rel = wdata;
      if (fire) m_fired = 1;
      else if (w_ctl && !wdata[4]) m_fired = 0;
      m_irq = fire;
      if (w_opt) begin m_scale = wdata[3]; m_p20en = wdata[2]; m_rsten = wdata[1]; end
      if (w_ctl) begin m_men = wdata[7]; m_ken = wdata[6]; m_sel = wdata[3:0]; end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R5 irq_o", irq_o, m_irq);
      chk("R11 smi_o", smi_o, m_irq && m_sel == 2);
      chk("R11 irq_sel_o", irq_sel_o, m_sel);
      chk("R10 kbrst_o", kbrst_o, m_rleft > 0);
      chk("R2 rdata", rdata_o, exp_rd(addr));
      if (irq_o) irq_cnt++;
      if (smi_o) smi_cnt++;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    addr = a[1:0]; wdata = d[7:0]; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, int exp, string req);
    addr = a[1:0]; #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
  endtask

  task automatic pulse_kbd();   kbd = 1'b1;   step(); kbd = 1'b0;   step(); endtask
  task automatic pulse_mouse(); mouse = 1'b1; step(); mouse = 1'b0; step(); endtask
  task automatic pulse_p20();   p20 = 1'b1;   step(); p20 = 1'b0;   step(); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    cmp_en = 1'b1;
    // R1 reset state
    rd(0, 0, "R1 opt"); rd(1, 0, "R1 cnt"); rd(2, 0, "R1 ctl"); rd(3, 0, "R1 unused");
    chk("R1 irq_o", irq_o, 0); chk("R1 kbrst_o", kbrst_o, 0); chk("R1 smi_o", smi_o, 0);

    // R2 zero disarms
    wr(1, 0); ticks(5);
    chk("R2 no expiry when disarmed", irq_cnt, 0); rd(1, 0, "R2 cnt");

    // R3 / R5 / R10 / R11 second countdown to expiry
    wr(0, 8'h02); wr(2, 8'h02);
    rd(0, 8'h02, "R10 opt readback"); rd(2, 8'h02, "R11 sel readback");
    wr(1, 3); rd(1, 3, "R2 armed count");
    ticks(1); rd(1, 2, "R3 decrement");
    ticks(1); rd(1, 1, "R3 decrement");
    base = irq_cnt;
    tick = 1'b1; step(); tick = 1'b0;
    chk("R5 irq pulse", irq_o, 1); chk("R10 kbrst start", kbrst_o, 1);
    chk("R11 smi with code 2", smi_o, 1);
    step();
    chk("R5 irq one cycle", irq_o, 0);
    repeat (14) step();
    chk("R10 kbrst still high", kbrst_o, 1);
    step();
    chk("R10 kbrst ends", kbrst_o, 0);
    chk("R5 one irq", irq_cnt, base + 1);
    rd(2, 8'h12, "R5 fired flag"); rd(1, 0, "R5 count zero");

    // R6 sticky flag freezes counting
    wr(1, 5); ticks(3);
    rd(1, 5, "R6 frozen while fired"); chk("R6 no refire", irq_cnt, base + 1);
    wr(2, 8'h12); rd(2, 8'h12, "R6 write one keeps flag");
    wr(2, 8'h02); rd(2, 8'h02, "R6 write zero clears");
    ticks(1); rd(1, 4, "R6 counts after clear");
    wr(1, 0);

    // R8 activity reload
    wr(0, 8'h00);
    wr(2, 8'h40); wr(1, 4); ticks(2); rd(1, 2, "R8 pre");
    pulse_kbd(); rd(1, 4, "R8 kbd reload");
    ticks(1); pulse_mouse(); rd(1, 3, "R8 mouse ignored when disabled");
    wr(2, 8'hC0); pulse_mouse(); rd(1, 4, "R8 mouse reload");
    wr(1, 0); pulse_kbd(); rd(1, 0, "R8 no reload when disarmed");

    // R7 forced expiry
    base = irq_cnt;
    wr(1, 9); wr(2, 8'h20); step();
    chk("R7 forced irq", irq_cnt, base + 1);
    rd(2, 8'h10, "R7 force reads zero, flag set"); rd(1, 0, "R7 count zero");
    wr(2, 0);

    // R9 P20 path
    base = irq_cnt;
    pulse_p20(); chk("R9 p20 ignored", irq_cnt, base); rd(2, 0, "R9 no flag");
    wr(0, 8'h04); pulse_p20();
    chk("R9 p20 fires", irq_cnt, base + 1); rd(2, 8'h10, "R9 flag set");
    wr(2, 0);

    // R4 minute scale and prescaler restart
    base = irq_cnt;
    wr(0, 8'h08); wr(1, 2);
    ticks(59); rd(1, 2, "R4 holds for 59 ticks");
    ticks(1);  rd(1, 1, "R4 minute step");
    ticks(30); wr(1, 1);
    ticks(59); rd(1, 1, "R4 restart on write"); chk("R4 no early fire", irq_cnt, base);
    ticks(1);  rd(1, 0, "R4 minute expiry"); chk("R4 fired", irq_cnt, base + 1);

    // unused address and selection field
    wr(3, 8'hFF); rd(0, 8'h08, "R1 unused write ignored"); rd(3, 0, "R1 unused reads zero");
    wr(2, 8'h07); chk("R11 sel port", irq_sel_o, 7); rd(2, 8'h07, "R11 ctl readback");
    step(); step();
    finish_run();
  end
endmodule